// File: doc/BRIEF.md
# Serial NOR flash word reader

This block lets a host fetch 32-bit words from a serial NOR flash over a four-wire SPI link. The host presents a 24-bit byte address and raises a request line. The block selects the flash, sends the fast-read opcode followed by the address, clocks eight dummy cycles, and shifts in 32 data bits. It then shows the word on its read-data output together with a one-cycle acknowledge.

The serial clock is generated from the single system clock at half its rate, in SPI mode 0. After a word has been delivered, the flash stays selected and the serial clock is parked low. If the next request asks for the address just past the previous word (previous address plus 4, modulo 2^24), the block clocks 32 more bits out of the open burst and does not send the command again. Any other address closes the burst. The select line then goes high for at least one cycle and a fresh command is sent. An asynchronous active-low reset returns the block to idle with the flash deselected.

Top module: `spi_word_reader`

## Requirements
- R1: While and after reset, and before any request, `cs_n` is 1, `sck` is 0 and `rd_ack` is 0.
- R2: A nonsequential access sends, MSB first on `mosi`, the opcode 0x0B followed by the 24 request address bits. That is 32 command bits in total.
- R3: A nonsequential access uses exactly 72 rising `sck` edges: 32 command, 8 dummy and 32 data.
- R4: `sck` runs at half the `clk` rate, with each high phase lasting exactly one `clk` cycle. `mosi` changes only on falling `sck` edges and never at a rising edge.
- R5: Data bits are taken MSB first. The first bit received becomes `rd_data[31]`, so the byte at the request address lands in bits 31:24 and the byte at address+3 lands in bits 7:0.
- R6: `rd_ack` is high for exactly one cycle per completed word, and only while `req_en` is high. If `req_en` is dropped before the word completes, no acknowledge is issued.
- R7: A request whose address equals the previous address plus 4 uses exactly 32 rising `sck` edges, with `cs_n` held low throughout and no command sent.
- R8: Between words, `sck` is held low and `cs_n` stays low.
- R9: A request at any address other than the previous address plus 4 takes `cs_n` high for at least one cycle before the new command.
- R10: The next-address compare wraps at 24 bits, so a request at 0x000000 following one at 0xFFFFFC is sequential.
- R11: Asserting `rst_n` low in the middle of a transfer takes `cs_n` high and `sck` low at once, without waiting for a clock edge. The next request is then nonsequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_en | input | 1 | Read request, held high until acknowledged |
| req_addr | input | 24 | Flash byte address of the word to read |
| rd_data | output | 32 | Word read from the flash |
| rd_ack | output | 1 | One-cycle pulse: `rd_data` holds the requested word |
| sck | output | 1 | Serial clock to the flash |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Flash select, active low |

## Verification
The bench targets the points where the continuation rule can go wrong, each of which would show up as a changed count of serial clock edges or a missing deselect gap:
- a backward jump, or a skip forward by 8, must reopen the burst with a full 72-edge command;
- a step past 0xFFFFFC must wrap to 0x000000 and stream on;
- an unaligned address must continue at itself plus 4.

A design that assembled bytes in the wrong order, or sampled one edge early, would return a word shifted or byte-swapped against the bench's flash model. That model drives its data 15 ns after each falling edge. Two further cases are covered:
- A request dropped mid-transfer must give no acknowledge but must still leave a valid open burst.
- A reset in mid-command must deselect the flash at once, which a synchronous reset would not do.

// File: rtl/spi_rd_pkg.sv
// Shared types and constants for the serial flash word reader.
// Assumes a flash that accepts the fast-read opcode with one dummy byte.
package spi_rd_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        S_IDLE,   // deselected, waiting for a request
        S_CMD,    // shifting opcode and address
        S_DUMMY,  // dummy clocks before data
        S_DATA,   // shifting in one word
        S_ACK,    // word complete, acknowledge cycle
        S_PARK    // selected, clock parked low, burst open
    } rd_state_t;

    // Fast-read opcode sent at the start of every burst
    localparam logic [7:0] FAST_READ_OP = 8'h0B;

endpackage

// File: rtl/spi_rd_tx_shift.sv
// Command shifter: loads opcode plus address and presents them MSB first.
// Assumes the caller pulses shift_en only at falling serial clock edges,
// so the output never changes while the serial clock is high.
module spi_rd_tx_shift #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] load_val,
    output logic             mosi
);

    logic [WIDTH-1:0] sr_q;

    // Load a new command or move the next bit to the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= load_val;
        else if (shift_en)
            sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end

    assign mosi = sr_q[WIDTH-1];

endmodule

// File: rtl/spi_rd_rx_shift.sv
// Data shifter: collects serial bits MSB first into one word.
// Assumes shift_en is pulsed once per bit, at the end of the high phase.
module spi_rd_rx_shift #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             miso,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] sr_q;

    // Append each sampled bit at the bottom; the first bit ends in the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= {sr_q[WIDTH-2:0], miso};
    end

    assign word = sr_q;

endmodule

// File: rtl/spi_rd_addr_track.sv
// Next-address tracker: remembers where an open burst will continue.
// Assumes capture is pulsed when a word access is accepted; the compare
// wraps at the address width, as the flash address counter does.
module spi_rd_addr_track #(
    parameter int ADDR_W     = 24,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_seq
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] next_q;

    // Record the address following the word now being read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            next_q <= '0;
        else if (capture)
            next_q <= addr + STEP;
    end

    assign is_seq = (addr == next_q);

endmodule

// File: rtl/spi_word_reader.sv
// Read-only serial NOR flash word reader using the fast-read command.
// Generates a mode-0 serial clock at half the clk rate; samples the input
// at the end of each high phase, which leaves a full clk period for the
// flash output delay. Keeps the burst open between words and continues it
// when the next request is the following word. Assumes the host holds
// req_en and req_addr steady until rd_ack.
module spi_word_reader
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int DUMMY_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ack,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    localparam int OP_W     = $bits(FAST_READ_OP);
    localparam int CMD_BITS = OP_W + ADDR_W;
    localparam int MAX_A    = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
    localparam int MAX_BITS = (MAX_A > DUMMY_BITS) ? MAX_A : DUMMY_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS);

    localparam logic [CNT_W-1:0] LAST_CMD   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);

    rd_state_t        state_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             sck_q;
    logic             cs_n_q;

    logic sck_fall;
    logic is_seq;
    logic tx_load;
    logic tx_shift;
    logic rx_shift;
    logic capture;

    // A clk edge that sees the serial clock high lowers it: the falling edge
    assign sck_fall = sck_q;
    assign tx_load  = (state_q == S_IDLE) && req_en;
    assign tx_shift = (state_q == S_CMD)  && sck_fall;
    assign rx_shift = (state_q == S_DATA) && sck_fall;
    assign capture  = tx_load || ((state_q == S_PARK) && req_en && is_seq);

    spi_rd_tx_shift #(.WIDTH(CMD_BITS)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .shift_en (tx_shift),
        .load_val ({FAST_READ_OP, req_addr}),
        .mosi     (mosi)
    );

    spi_rd_rx_shift #(.WIDTH(DATA_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_shift),
        .miso     (miso),
        .word     (rd_data)
    );

    spi_rd_addr_track #(.ADDR_W(ADDR_W), .WORD_BYTES(DATA_W / 8)) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .addr    (req_addr),
        .is_seq  (is_seq)
    );

    // Sequence the burst phases, the serial clock, the select and the bit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            bit_cnt_q <= '0;
            sck_q     <= 1'b0;
            cs_n_q    <= 1'b1;
        end else begin
            case (state_q)
                S_IDLE: begin
                    sck_q <= 1'b0;
                    if (req_en) begin
                        cs_n_q    <= 1'b0;
                        bit_cnt_q <= '0;
                        state_q   <= S_CMD;
                    end
                end
                S_CMD: begin
                    sck_q <= ~sck_q;
                    if (sck_fall) begin
                        if (bit_cnt_q == LAST_CMD) begin
                            bit_cnt_q <= '0;
                            state_q   <= S_DUMMY;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                end
                S_DUMMY: begin
                    sck_q <= ~sck_q;
                    if (sck_fall) begin
                        if (bit_cnt_q == LAST_DUMMY) begin
                            bit_cnt_q <= '0;
                            state_q   <= S_DATA;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                end
                S_DATA: begin
                    sck_q <= ~sck_q;
                    if (sck_fall) begin
                        if (bit_cnt_q == LAST_DATA) begin
                            bit_cnt_q <= '0;
                            state_q   <= S_ACK;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                end
                S_ACK: begin
                    state_q <= S_PARK;
                end
                S_PARK: begin
                    if (req_en) begin
                        bit_cnt_q <= '0;
                        if (is_seq) begin
                            state_q <= S_DATA;
                        end else begin
                            cs_n_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                    sck_q   <= 1'b0;
                    cs_n_q  <= 1'b1;
                end
            endcase
        end
    end

    assign sck    = sck_q;
    assign cs_n   = cs_n_q;
    assign rd_ack = (state_q == S_ACK) && req_en;

    // R4: the serial clock is high for a single clk cycle at a time
    a_r4_sck_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);

    // R4: the serial clock only pulses while the flash is selected
    a_r4_sck_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    // R6: the acknowledge is a single-cycle pulse
    a_r6_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);

    // R8: a delivered word leaves the flash selected with the clock parked low
    a_r8_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (!sck && !cs_n));

    // R9: the select never reasserts straight from the data phase
    a_r9_select_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sck);

endmodule

// File: tb/spi_word_reader_tb_top.sv
// Bench for the serial flash word reader: a vector table of reads walked
// by one loop, then directed tests for a dropped request and a mid-burst
// reset. A behavioural flash answers fast-read with 15 ns output delay.
module spi_word_reader_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int NVEC       = 10;

    // {address, expected to continue the open burst}
    localparam logic [24:0] VEC [0:NVEC-1] = '{
        {24'h000000, 1'b0},
        {24'h000004, 1'b1},
        {24'h000008, 1'b1},
        {24'h000100, 1'b0},
        {24'h000107, 1'b0},
        {24'h00010B, 1'b1},
        {24'hFFFFFC, 1'b0},
        {24'h000000, 1'b1},
        {24'h000008, 1'b0},
        {24'h000004, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] rd_data;
    logic        rd_ack;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic        cs_n;

    int checks = 0;
    int errors = 0;

    spi_word_reader dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (req_en),
        .req_addr (req_addr),
        .rd_data  (rd_data),
        .rd_ack   (rd_ack),
        .sck      (sck),
        .mosi     (mosi),
        .miso     (miso),
        .cs_n     (cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Flash contents as a function of byte address
    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return (a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A) + a[23:16];
    endfunction

    function automatic logic [31:0] word_of(input logic [23:0] a);
        return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
    endfunction

    // Behavioural flash: command in on rising edges, data out after falling edges
    int          fl_cnt = 0;
    logic [31:0] fl_cmd_sr = '0;
    logic [31:0] fl_cmd_seen = '0;
    logic [23:0] fl_addr = '0;
    int          rises = 0;

    always @(posedge cs_n) fl_cnt = 0;

    always @(posedge sck) begin
        if (fl_cnt < 32) begin
            fl_cmd_sr = {fl_cmd_sr[30:0], mosi};
            if (fl_cnt == 31) begin
                fl_cmd_seen = fl_cmd_sr;
                fl_addr     = fl_cmd_sr[23:0];
            end
        end
        fl_cnt = fl_cnt + 1;
        rises  = rises + 1;
    end

    always @(negedge sck) begin
        if (fl_cnt >= 40) begin
            int          idx;
            logic [7:0]  bv;
            idx = fl_cnt - 40;
            bv  = fbyte(fl_addr + 24'(idx / 8));
            #15;
            miso = bv[7 - (idx % 8)];
        end
    end

    // Monitors sampled away from the active edge
    logic prev_sck = 1'b0;
    logic prev_mosi = 1'b0;
    int   r4_bad = 0;
    int   ack_count = 0;
    bit   saw_desel = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sck && prev_sck) r4_bad++;
            if (sck && !prev_sck && (mosi !== prev_mosi)) r4_bad++;
            if (rd_ack) ack_count++;
            if (req_en && cs_n) saw_desel = 1'b1;
        end
        prev_sck  = sck;
        prev_mosi = mosi;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One word read with full checking of the link activity it caused
    task automatic do_read(input logic [23:0] a, input bit exp_seq);
        int waited = 0;
        bit got = 1'b0;
        @(negedge clk);
        req_addr  = a;
        req_en    = 1'b1;
        rises     = 0;
        saw_desel = 1'b0;
        while (!got && waited < 2000) begin
            @(negedge clk);
            waited++;
            if (rd_ack) got = 1'b1;
        end
        chk(got, "R6 ack for completed word", 64'(got), 64'd1);
        chk(rd_data == word_of(a), "R5 word assembly", 64'(rd_data), 64'(word_of(a)));
        if (exp_seq) begin
            chk(rises == 32, "R7 sequential clock count", 64'(rises), 64'd32);
            chk(!saw_desel, "R7 select held in burst", 64'(saw_desel), 64'd0);
        end else begin
            chk(rises == 72, "R3 nonsequential clock count", 64'(rises), 64'd72);
            chk(fl_cmd_seen == {8'h0B, a}, "R2 opcode and address",
                64'(fl_cmd_seen), 64'({8'h0B, a}));
            chk(saw_desel, "R9 deselect gap", 64'(saw_desel), 64'd1);
        end
        req_en = 1'b0;
        @(negedge clk);
        chk(!rd_ack && !sck && !cs_n, "R8 parked between words",
            64'({rd_ack, sck, cs_n}), 64'd0);
    endtask

    // Global watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n && !sck && !rd_ack, "R1 during reset", 64'({cs_n, sck, rd_ack}), 64'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !sck && !rd_ack, "R1 idle after reset", 64'({cs_n, sck, rd_ack}), 64'h4);

        // Vector table: R2 R3 R5 R7 R9, and R10 at the 0xFFFFFC -> 0 step
        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][24:1], VEC[i][0]);
        end

        // R6: a request dropped before completion gets no acknowledge
        ack_count = 0;
        @(negedge clk);
        req_addr = 24'h000200;
        req_en   = 1'b1;
        repeat (60) @(negedge clk);
        req_en = 1'b0;
        repeat (200) @(negedge clk);
        chk(ack_count == 0, "R6 no ack after drop", 64'(ack_count), 64'd0);
        // The burst was still completed, so the next word continues it
        do_read(24'h000204, 1'b1);

        // R11: asynchronous reset in mid-command
        @(negedge clk);
        req_addr = 24'h012340;
        req_en   = 1'b1;
        repeat (30) @(negedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        chk(cs_n && !sck, "R11 immediate deselect", 64'({cs_n, sck}), 64'h2);
        req_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11: after reset the next access is a fresh command
        do_read(24'h012344, 1'b0);

        // R4: clock phase and data-change discipline over the whole run
        chk(r4_bad == 0, "R4 half-rate clock and mosi timing", 64'(r4_bad), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule